// File: doc/BRIEF.md
# Sequential-Wakeup Issue Queue

This block is a small out-of-order issue queue. Each entry holds one destination tag and two source tags, each source with a ready bit. At dispatch, one source is marked as the one predicted to arrive last. Only that source compares against the fast broadcast bus. The fast bus carries, in the same cycle, the external destination-tag broadcasts and the tags of the entries being granted. The other source compares only against a slow bus, which is a one-cycle registered copy of the fast bus. A wrong prediction therefore costs one cycle of latency and never needs a replay. The same one-cycle cost applies when both sources become ready in the same cycle.

An entry requests issue once both of its ready bits are set. An oldest-first selector grants up to four requesting entries per cycle, where a lower slot index counts as older. The selector drives the granted destination tags out on the issue lanes, and those tags also go onto the fast bus to wake up dependent entries. A granted entry becomes free in the following cycle.

Each entry keeps its own small state machine with three states:

- **ST_FREE** is the empty slot.
- **ST_WAIT** means the entry holds an instruction with at least one source pending.
- **ST_REQ** means both sources are ready and the entry is requesting issue.

The transitions are:

- **FREE→WAIT**: allocation with a source still pending.
- **FREE→REQ**: allocation with both sources ready.
- **WAIT→REQ**: the last pending source wakes up.
- **REQ→FREE**: the entry is granted.

Top module: `seqwake_iq`

## Requirements
- R1: An entry requests issue only when both of its source ready bits are set; an entry with a source still pending never appears on an issue lane.
- R2: A granted entry's destination tag appears on the issue lanes in its grant cycle and is broadcast on the fast bus that same cycle. A waiting entry whose predicted-last source carries that tag, with the other source ready, issues in the very next cycle.
- R3: The predicted-last source (`disp_last1`=1 selects source 1, 0 selects source 0) wakes from an external broadcast on `bc_valid`/`bc_tag` in cycle t, and the entry issues in cycle t+1.
- R4: The other source ignores the fast bus and wakes only from the slow bus, which is the fast bus delayed by one register. A broadcast in cycle t lets the entry issue in cycle t+2. The entry's `slow_woke` bit (bit index = slot) reads 0 in cycle t+1 and 1 from cycle t+2.
- R5: On a misprediction, or when both sources are broadcast in the same cycle, the entry issues exactly once, one cycle later than a fast wakeup would allow, with no replay. `slow_woke` is cleared when a slot is allocated.
- R6: At most four entries are granted per cycle, chosen by lowest slot index first. Lanes are filled from lane 0 upward in ascending slot order, and the remaining ready entries are granted in later cycles.
- R7: A source that is flagged ready at dispatch (`disp_rdy0`/`disp_rdy1`), or whose tag is 0, is ready immediately. An entry dispatched in cycle t with both sources ready issues in cycle t+1.
- R8: Dispatch goes to the lowest free slot. `disp_ready` is 0 while all 16 slots are occupied, and a dispatch offered then is ignored. A slot granted in cycle t is free again in cycle t+1. After reset, `disp_ready` is 1, no lane is valid and `slow_woke` is all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request this cycle |
| disp_dst | input | TAG_W | Destination tag of dispatched instruction |
| disp_src0 | input | TAG_W | Source 0 tag |
| disp_src1 | input | TAG_W | Source 1 tag |
| disp_rdy0 | input | 1 | Source 0 already ready |
| disp_rdy1 | input | 1 | Source 1 already ready |
| disp_last1 | input | 1 | 1: source 1 predicted last; 0: source 0 predicted last |
| disp_ready | output | 1 | A free slot exists; dispatch accepted |
| bc_valid | input | WAYS | External broadcast lane valids |
| bc_tag | input | WAYS*TAG_W | External broadcast tags, lane w at bits w*TAG_W |
| issue_valid | output | WAYS | Grant lane valids |
| issue_tag | output | WAYS*TAG_W | Granted destination tags, lane w at bits w*TAG_W |
| slow_woke | output | DEPTH | Per-slot flag: the entry woke through the slow bus |

## Verification
The first pattern dispatches entries that are ready through their flags and entries that are ready because their tags are zero. This separates the immediate-ready path from any wakeup path. A second pattern sends an external broadcast to the predicted-last source and then chains a dependent on the resulting grant. It measures fast wakeup and back-to-back issue to the exact cycle.

Misprediction and same-cycle arrival of both sources must each land exactly two cycles after the broadcast. Watching the `slow_woke` flag in the two cycles around that point separates the delayed bus from a missing wakeup or a double issue. Finally, a group of six entries released together, and then a completely full queue released at once, expose the four-grant limit, the lowest-slot priority, the rule against dispatching into a full queue and the timing of slot reuse.

// File: rtl/seqwake_pkg.sv
package seqwake_pkg;
    typedef enum logic [1:0] {
        ST_FREE = 2'd0,
        ST_WAIT = 2'd1,
        ST_REQ  = 2'd2
    } ent_state_t;
endpackage

// File: rtl/seqwake_entry.sv
module seqwake_entry
    import seqwake_pkg::*;
#(
    parameter int TAG_W = 6,
    parameter int NBUS  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               alloc,
    input  logic [TAG_W-1:0]   d_dst,
    input  logic [TAG_W-1:0]   d_src0,
    input  logic [TAG_W-1:0]   d_src1,
    input  logic               d_rdy0,
    input  logic               d_rdy1,
    input  logic               d_last1,
    input  logic [NBUS-1:0]    fast_vld,
    input  logic [NBUS*TAG_W-1:0] fast_tag,
    input  logic [NBUS-1:0]    slow_vld,
    input  logic [NBUS*TAG_W-1:0] slow_tag,
    input  logic               grant,
    output logic               req,
    output logic               is_free,
    output logic [TAG_W-1:0]   dst,
    output logic               slow_woke
);
    ent_state_t       state_q, state_n;
    logic [TAG_W-1:0] dst_q, ftag_q, stag_q;
    logic             frdy_q, srdy_q, swoke_q;
    logic             hit_fast, hit_slow;
    logic [TAG_W-1:0] in_ftag, in_stag;
    logic             in_frdy, in_srdy;

    // pick which source watches which bus at dispatch
    always_comb begin
        in_ftag = d_last1 ? d_src1 : d_src0;
        in_stag = d_last1 ? d_src0 : d_src1;
        in_frdy = d_last1 ? (d_rdy1 || d_src1 == '0) : (d_rdy0 || d_src0 == '0);
        in_srdy = d_last1 ? (d_rdy0 || d_src0 == '0) : (d_rdy1 || d_src1 == '0);
    end

    // one tag watcher per bus
    always_comb begin
        hit_fast = 1'b0;
        hit_slow = 1'b0;
        for (int k = 0; k < NBUS; k++) begin
            if (fast_vld[k] && fast_tag[k*TAG_W +: TAG_W] == ftag_q) hit_fast = 1'b1;
            if (slow_vld[k] && slow_tag[k*TAG_W +: TAG_W] == stag_q) hit_slow = 1'b1;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_FREE: if (alloc) state_n = (in_frdy && in_srdy) ? ST_REQ : ST_WAIT;
            ST_WAIT: if ((frdy_q || hit_fast) && (srdy_q || hit_slow)) state_n = ST_REQ;
            ST_REQ:  if (grant) state_n = ST_FREE;
            default: state_n = ST_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FREE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q   <= '0;
            ftag_q  <= '0;
            stag_q  <= '0;
            frdy_q  <= 1'b0;
            srdy_q  <= 1'b0;
            swoke_q <= 1'b0;
        end else if (alloc && state_q == ST_FREE) begin
            dst_q   <= d_dst;
            ftag_q  <= in_ftag;
            stag_q  <= in_stag;
            frdy_q  <= in_frdy;
            srdy_q  <= in_srdy;
            swoke_q <= 1'b0;
        end else if (state_q == ST_WAIT) begin
            frdy_q <= frdy_q | hit_fast;
            srdy_q <= srdy_q | hit_slow;
            if (!srdy_q && hit_slow) swoke_q <= 1'b1;
        end
    end

    always_comb begin
        req       = (state_q == ST_REQ);
        is_free   = (state_q == ST_FREE);
        dst       = dst_q;
        slow_woke = swoke_q;
    end

    AST_REQ_BOTH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (frdy_q && srdy_q)); // R1
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> req); // R6
    AST_FREE_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        grant |=> is_free); // R8
    AST_ALLOC_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc |-> is_free); // R8
endmodule

// File: rtl/seqwake_select.sv
module seqwake_select #(
    parameter int DEPTH = 16,
    parameter int WAYS  = 4,
    parameter int IDX_W = 4
) (
    input  logic [DEPTH-1:0]      req,
    output logic [DEPTH-1:0]      grant,
    output logic [WAYS-1:0]       lane_vld,
    output logic [WAYS*IDX_W-1:0] lane_idx
);
    logic [DEPTH-1:0] left;

    always_comb begin
        left     = req;
        grant    = '0;
        lane_vld = '0;
        lane_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (!lane_vld[w] && left[i]) begin
                    lane_vld[w]                 = 1'b1;
                    lane_idx[w*IDX_W +: IDX_W]  = IDX_W'(i);
                    left[i]                     = 1'b0;
                    grant[i]                    = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/seqwake_iq.sv
module seqwake_iq #(
    parameter int DEPTH = 16,
    parameter int WAYS  = 4,
    parameter int TAG_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  disp_valid,
    input  logic [TAG_W-1:0]      disp_dst,
    input  logic [TAG_W-1:0]      disp_src0,
    input  logic [TAG_W-1:0]      disp_src1,
    input  logic                  disp_rdy0,
    input  logic                  disp_rdy1,
    input  logic                  disp_last1,
    output logic                  disp_ready,
    input  logic [WAYS-1:0]       bc_valid,
    input  logic [WAYS*TAG_W-1:0] bc_tag,
    output logic [WAYS-1:0]       issue_valid,
    output logic [WAYS*TAG_W-1:0] issue_tag,
    output logic [DEPTH-1:0]      slow_woke
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int NBUS  = 2 * WAYS;

    logic [DEPTH-1:0]       req_vec, free_vec, grant_vec, alloc_vec;
    logic [DEPTH*TAG_W-1:0] dst_flat;
    logic [WAYS-1:0]        lane_vld;
    logic [WAYS*IDX_W-1:0]  lane_idx;
    logic [NBUS-1:0]        fast_vld, slow_vld_q;
    logic [NBUS*TAG_W-1:0]  fast_tag, slow_tag_q;
    logic                   found;

    // lowest free slot takes the dispatch
    always_comb begin
        alloc_vec = '0;
        found     = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!found && free_vec[i]) begin
                found        = 1'b1;
                alloc_vec[i] = disp_valid;
            end
        end
        disp_ready = found;
    end

    seqwake_select #(.DEPTH(DEPTH), .WAYS(WAYS), .IDX_W(IDX_W)) u_sel (
        .req(req_vec), .grant(grant_vec), .lane_vld(lane_vld), .lane_idx(lane_idx)
    );

    always_comb begin
        issue_valid = lane_vld;
        issue_tag   = '0;
        for (int w = 0; w < WAYS; w++)
            for (int i = 0; i < DEPTH; i++)
                if (lane_vld[w] && lane_idx[w*IDX_W +: IDX_W] == IDX_W'(i))
                    issue_tag[w*TAG_W +: TAG_W] = dst_flat[i*TAG_W +: TAG_W];
        fast_vld = {lane_vld, bc_valid};
        fast_tag = {issue_tag, bc_tag};
    end

    // slow bus: fast bus one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_vld_q <= '0;
            slow_tag_q <= '0;
        end else begin
            slow_vld_q <= fast_vld;
            slow_tag_q <= fast_tag;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        seqwake_entry #(.TAG_W(TAG_W), .NBUS(NBUS)) u_ent (
            .clk(clk), .rst_n(rst_n), .alloc(alloc_vec[g]),
            .d_dst(disp_dst), .d_src0(disp_src0), .d_src1(disp_src1),
            .d_rdy0(disp_rdy0), .d_rdy1(disp_rdy1), .d_last1(disp_last1),
            .fast_vld(fast_vld), .fast_tag(fast_tag),
            .slow_vld(slow_vld_q), .slow_tag(slow_tag_q),
            .grant(grant_vec[g]), .req(req_vec[g]), .is_free(free_vec[g]),
            .dst(dst_flat[g*TAG_W +: TAG_W]), .slow_woke(slow_woke[g])
        );
    end

    AST_GRANT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_vec) <= WAYS); // R6
    AST_ONE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(alloc_vec)); // R8
    AST_NO_DISP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_ready |-> (alloc_vec == '0)); // R8

    for (genvar w = 1; w < WAYS; w++) begin : g_lane_chk
        AST_LANE_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[w] |-> (issue_valid[w-1] &&
                lane_idx[w*IDX_W +: IDX_W] > lane_idx[(w-1)*IDX_W +: IDX_W])); // R6
    end
endmodule

// File: tb/seqwake_iq_tb.sv
module seqwake_iq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int WAYS  = 4;
    localparam int TAG_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic disp_valid = 1'b0;
    logic [TAG_W-1:0] disp_dst = '0, disp_src0 = '0, disp_src1 = '0;
    logic disp_rdy0 = 1'b0, disp_rdy1 = 1'b0, disp_last1 = 1'b0;
    logic disp_ready;
    logic [WAYS-1:0] bc_valid = '0;
    logic [WAYS*TAG_W-1:0] bc_tag = '0;
    logic [WAYS-1:0] issue_valid;
    logic [WAYS*TAG_W-1:0] issue_tag;
    logic [DEPTH-1:0] slow_woke;

    int cyc = 0;
    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;
    int    exp_tag[$];
    int    exp_cyc[$];
    string exp_req[$];

    seqwake_iq #(.DEPTH(DEPTH), .WAYS(WAYS), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_src0(disp_src0), .disp_src1(disp_src1), .disp_rdy0(disp_rdy0),
        .disp_rdy1(disp_rdy1), .disp_last1(disp_last1), .disp_ready(disp_ready),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .issue_valid(issue_valid),
        .issue_tag(issue_tag), .slow_woke(slow_woke)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic push(input int tag, input int c, input string req);
        exp_tag.push_back(tag);
        exp_cyc.push_back(c);
        exp_req.push_back(req);
    endtask

    // driver: dispatch one instruction in the current window
    task automatic disp(input int d, input int s0, input int s1, input bit r0,
                        input bit r1, input bit l1, input bit ready_now, input string req);
        int k;
        k = cyc;
        disp_valid = 1'b1;
        disp_dst = TAG_W'(d); disp_src0 = TAG_W'(s0); disp_src1 = TAG_W'(s1);
        disp_rdy0 = r0; disp_rdy1 = r1; disp_last1 = l1;
        if (ready_now) push(d, k + 1, req);
        @(negedge clk);
        disp_valid = 1'b0;
    endtask

    task automatic bcast(input int t0, input bit v1, input int t1, output int k);
        k = cyc;
        bc_valid = {2'b00, v1, 1'b1};
        bc_tag   = '0;
        bc_tag[0 +: TAG_W]     = TAG_W'(t0);
        bc_tag[TAG_W +: TAG_W] = TAG_W'(t1);
        @(negedge clk);
        bc_valid = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare each issue lane against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && !finished) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (issue_valid[w]) begin
                        if (exp_tag.size() == 0) begin
                            chk("R1 unexpected issue", int'(issue_tag[w*TAG_W +: TAG_W]), -1);
                        end else begin
                            int et, ec;
                            string er;
                            et = exp_tag.pop_front();
                            ec = exp_cyc.pop_front();
                            er = exp_req.pop_front();
                            chk({er, " issue tag"}, int'(issue_tag[w*TAG_W +: TAG_W]), et);
                            chk({er, " issue cycle"}, cyc, ec);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++; nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        int j;
        idle(3);
        rst_n = 1'b1;
        #1;
        chk("R8 reset disp_ready", int'(disp_ready), 1);
        chk("R8 reset issue_valid", int'(issue_valid), 0);
        chk("R8 reset slow_woke", int'(slow_woke), 0);
        @(negedge clk);

        // R7: ready at dispatch by flag or by zero tag
        disp(1, 5, 7, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        disp(2, 0, 0, 1'b0, 1'b0, 1'b1, 1'b1, "R7");
        idle(4);

        // R3 fast wakeup, then R2 back-to-back dependent
        disp(8, 10, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        disp(9, 8, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        idle(2);
        chk("R1 no issue while pending", int'(issue_valid), 0);
        bcast(10, 1'b0, 0, j);
        push(8, j + 1, "R3");
        push(9, j + 2, "R2");
        idle(5);

        // R4 misprediction: pending source sits on the slow bus
        disp(4, 11, 0, 1'b0, 1'b0, 1'b1, 1'b0, "R4");
        idle(2);
        bcast(11, 1'b0, 0, j);
        push(4, j + 2, "R4");
        #1 chk("R4 slow_woke before", int'(slow_woke[0]), 0);
        @(negedge clk);
        #1 chk("R4 slow_woke after", int'(slow_woke[0]), 1);
        idle(4);

        // R5 both sources broadcast in the same cycle
        disp(5, 12, 13, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        idle(1);
        #1 chk("R5 slow_woke cleared on alloc", int'(slow_woke[0]), 0);
        bcast(12, 1'b1, 13, j);
        push(5, j + 2, "R5");
        @(negedge clk);
        #1 chk("R5 slow_woke set", int'(slow_woke[0]), 1);
        idle(5);

        // R6 six entries released at once
        for (int i = 0; i < 6; i++) disp(20 + i, 19, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        idle(1);
        bcast(19, 1'b0, 0, j);
        for (int i = 0; i < 6; i++) push(20 + i, j + 1 + i / 4, "R6");
        idle(6);

        // R8 fill the queue, offer a dispatch while full, release all
        for (int i = 0; i < DEPTH; i++) disp(32 + i, 50, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
        #1 chk("R8 full disp_ready", int'(disp_ready), 0);
        disp(60, 0, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        #1 chk("R8 still full", int'(disp_ready), 0);
        bcast(50, 1'b0, 0, j);
        for (int i = 0; i < DEPTH; i++) push(32 + i, j + 1 + i / 4, "R6");
        @(negedge clk);
        #1 chk("R8 slots reused after grant", int'(disp_ready), 1);
        idle(10);

        chk("R6 scoreboard drained", exp_tag.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule